// File: doc/BRIEF.md
# Order-Preserving Output Scheduler

This block serves one output of a four-by-four packet switch. Each input port that has stored a packet for this output raises a request carrying the index of the buffer slot that holds it. The block queues these slot indices per input and, whenever a packet is waiting, presents a grant naming the input and slot the transmitter should read next. When the transmitter takes the grant by raising its ready line, that entry is retired on the same clock edge.

Any waiting input may win the output, but packets that arrived on the same input leave in their arrival order. Inputs compete round-robin, so no input can starve another. A request made to an idle output shows up as a grant in the cycle right after the edge that captured it, with no idle cycle in between.

The control is a two-state machine. In `SCH_EMPTY` nothing is waiting and no grant is offered. In `SCH_PENDING` at least one packet is waiting and a grant is offered. The transition `go_pending` fires when any request is accepted while empty. The transition `go_empty` fires when the last waiting packet is retired and no new request arrives on that edge. In every other case the machine stays where it is (`stay_empty`, `stay_pending`).

Top module: `osch_top`

## Requirements
- R1: After reset, `grant_valid` is low and no packet is waiting. A reset applied while entries are queued discards them all.
- R2: A request on input i with slot s, made while nothing else is waiting, gives `grant_valid`=1, `grant_port`=i and `grant_slot`=s in the cycle after the capturing edge. Input i's slot is `req_slot[2i+1:2i]`.
- R3: Slots requested on one input are granted in the order in which they were requested.
- R4: When several inputs are waiting, the winner is the first waiting input found by searching upward, with wraparound, from the input granted last. After reset the search starts at input 0.
- R5: While `tx_ready` is low, no entry is retired. With no new requests, the grant outputs hold their values.
- R6: Requests on several inputs in one cycle are all captured on the same edge.
- R7: A request and a retirement on the same input in the same cycle both take effect.
- R8: The state is `SCH_PENDING` exactly when some input queue is non-empty, and `grant_valid` is high only in `SCH_PENDING`.
- R9: Each input queue holds four slots. A request on a full queue with no retirement from it in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | One request strobe per input port |
| req_slot | input | 8 | Slot index per input, two bits each, input 0 in the low bits |
| tx_ready | input | 1 | Transmitter takes the offered grant on this edge |
| grant_valid | output | 1 | A waiting packet is offered |
| grant_port | output | 2 | Input port of the offered packet |
| grant_slot | output | 2 | Buffer slot of the offered packet |

## Verification
The bench builds the block with its defaults: four inputs and a four-deep queue per input. This keeps a full queue reachable in four requests and makes the round-robin pointer wrap within a short table. These values bring within reach the R9 overflow case, a push and a retirement on the same input in one cycle, and an all-inputs burst whose grant order depends on where the pointer was left.

// File: rtl/osch_pkg.sv
package osch_pkg;
    typedef enum logic {
        SCH_EMPTY   = 1'b0,
        SCH_PENDING = 1'b1
    } sched_state_t;
endpackage

// File: rtl/osch_slot_fifo.sv
module osch_slot_fifo #(
    parameter int DEPTH  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              pop,
    output logic              accepted,
    output logic              nonempty,
    output logic [SLOT_W-1:0] head_slot
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SLOT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              full;

    assign full      = (count == CNT_W'(DEPTH));
    assign nonempty  = (count != '0);
    assign accepted  = push && (!full || pop);
    assign head_slot = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) begin
                mem[wr_ptr] <= push_slot;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(accepted) - CNT_W'(pop);
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));

    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/osch_rr_pick.sv
module osch_rr_pick #(
    parameter int NUM_IN = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_IN-1:0] req,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [NUM_IN-1:0] gnt,
    output logic [IDX_W-1:0]  win_idx
);
    always_comb begin
        logic found;
        found   = 1'b0;
        gnt     = '0;
        win_idx = '0;
        for (int off = 1; off <= NUM_IN; off++) begin
            int cand;
            cand = (int'(last_idx) + off) % NUM_IN;
            if (!found && req[cand]) begin
                found     = 1'b1;
                gnt[cand] = 1'b1;
                win_idx   = IDX_W'(cand);
            end
        end
    end

    always_comb begin
        a_onehot_r4: assert ($onehot0(gnt));
        a_gnt_subset_r4: assert ((gnt & ~req) == '0);
    end
endmodule

// File: rtl/osch_top.sv
module osch_top #(
    parameter int NUM_IN = 4,
    parameter int DEPTH  = 4,
    parameter int SLOT_W = 2,
    parameter int PORT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN-1:0]        req_valid,
    input  logic [NUM_IN*SLOT_W-1:0] req_slot,
    input  logic                     tx_ready,
    output logic                     grant_valid,
    output logic [PORT_W-1:0]        grant_port,
    output logic [SLOT_W-1:0]        grant_slot
);
    import osch_pkg::*;

    localparam int TOTAL = NUM_IN * DEPTH;
    localparam int CNT_W = $clog2(TOTAL + 1);

    sched_state_t      state_q, state_d;
    logic [CNT_W-1:0]  wait_q, wait_d;
    logic [PORT_W-1:0] last_q;
    logic [NUM_IN-1:0] nonempty, acc, gnt, pop;
    logic [SLOT_W-1:0] heads [NUM_IN];
    logic [PORT_W-1:0] win_idx;
    logic              take;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_queue
        osch_slot_fifo #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (req_valid[i]),
            .push_slot(req_slot[i*SLOT_W +: SLOT_W]),
            .pop      (pop[i]),
            .accepted (acc[i]),
            .nonempty (nonempty[i]),
            .head_slot(heads[i])
        );
        assign pop[i] = take && gnt[i];
    end

    osch_rr_pick #(.NUM_IN(NUM_IN), .IDX_W(PORT_W)) u_pick (
        .req     (nonempty),
        .last_idx(last_q),
        .gnt     (gnt),
        .win_idx (win_idx)
    );

    assign take   = tx_ready && grant_valid;
    assign wait_d = wait_q + CNT_W'($countones(acc)) - CNT_W'(take);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_EMPTY:   if (|acc)            state_d = SCH_PENDING;
            SCH_PENDING: if (wait_d == '0)    state_d = SCH_EMPTY;
            default:                          state_d = SCH_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_EMPTY;
            wait_q  <= '0;
            last_q  <= PORT_W'(NUM_IN - 1);
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            if (take) last_q <= win_idx;
        end
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_port  = '0;
        grant_slot  = '0;
        unique case (state_q)
            SCH_EMPTY: ;
            SCH_PENDING: begin
                grant_valid = 1'b1;
                grant_port  = win_idx;
                grant_slot  = heads[win_idx];
            end
            default: ;
        endcase
    end

    p_state_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_PENDING) == (|nonempty));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !tx_ready && !(|req_valid)) |=>
            (grant_valid && $stable(grant_port) && $stable(grant_slot)));

    p_prompt_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |=> grant_valid);
endmodule

// File: tb/osch_top_tb.sv
module osch_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_valid = '0;
    logic [7:0] req_slot = '0;
    logic       tx_ready = 1'b0;
    logic       grant_valid;
    logic [1:0] grant_port, grant_slot;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    osch_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
        .tx_ready(tx_ready), .grant_valid(grant_valid),
        .grant_port(grant_port), .grant_slot(grant_slot)
    );

    // row: req_valid, slots {in3,in2,in1,in0}, ready, exp_valid, exp_port, exp_slot
    localparam int ROWS = 16;
    localparam logic [17:0] VEC [ROWS] = '{
        {4'b0100, 8'h10, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b0101, 8'h03, 1'b0, 1'b1, 2'd2, 2'd1},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd0, 2'd3},
        {4'b0010, 8'h08, 1'b1, 1'b1, 2'd2, 2'd1},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd1, 2'd2},
        {4'b0100, 8'h30, 1'b1, 1'b1, 2'd2, 2'd0},
        {4'b1000, 8'h40, 1'b0, 1'b1, 2'd2, 2'd3},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd3, 2'd1},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd2, 2'd3},
        {4'b0000, 8'h00, 1'b1, 1'b0, 2'd0, 2'd0},
        {4'b1111, 8'hE4, 1'b0, 1'b0, 2'd0, 2'd0},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd3, 2'd3},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd0, 2'd0},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd1, 2'd1},
        {4'b0000, 8'h00, 1'b1, 1'b1, 2'd2, 2'd2},
        {4'b0000, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0}
    };

    task automatic expect_out(input logic v, input logic [1:0] p, input logic [1:0] s,
                              input string tag);
        n_checks++;
        if (grant_valid !== v || (v && (grant_port !== p || grant_slot !== s))) begin
            n_errors++;
            $display("FAIL %s: got v=%0b p=%0d s=%0d, expected v=%0b p=%0d s=%0d",
                     tag, grant_valid, grant_port, grant_slot, v, p, s);
        end
    endtask

    task automatic drive_edge(input logic [3:0] rv, input logic [7:0] rs, input logic rdy);
        req_valid = rv;
        req_slot  = rs;
        tx_ready  = rdy;
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        req_slot  = '0;
        tx_ready  = 1'b0;
    endtask

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out(1'b0, 2'd0, 2'd0, "R1 reset idle");
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 2'd0, 2'd0, "R1 after release");

        // table covers R2 R4 R5 R6 R7 R8
        for (int i = 0; i < ROWS; i++) begin
            expect_out(VEC[i][4], VEC[i][3:2], VEC[i][1:0], $sformatf("R2/R4/R6/R7/R8 row %0d", i));
            drive_edge(VEC[i][17:14], VEC[i][13:6], VEC[i][5]);
        end

        // R3: order on one input (pointer left at input 2)
        drive_edge(4'b0010, 8'h08, 1'b0);
        drive_edge(4'b0010, 8'h00, 1'b0);
        drive_edge(4'b0010, 8'h0C, 1'b0);
        drive_edge(4'b0010, 8'h04, 1'b0);
        expect_out(1'b1, 2'd1, 2'd2, "R3 first");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b1, 2'd1, 2'd0, "R3 second");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b1, 2'd1, 2'd3, "R3 third");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b1, 2'd1, 2'd1, "R3 fourth");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b0, 2'd0, 2'd0, "R3 drained");

        // R9: fifth request on a full queue is dropped
        drive_edge(4'b0001, 8'h01, 1'b0);
        drive_edge(4'b0001, 8'h02, 1'b0);
        drive_edge(4'b0001, 8'h03, 1'b0);
        drive_edge(4'b0001, 8'h00, 1'b0);
        drive_edge(4'b0001, 8'h02, 1'b0);
        expect_out(1'b1, 2'd0, 2'd1, "R9 head");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b1, 2'd0, 2'd2, "R9 second");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b1, 2'd0, 2'd3, "R9 third");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b1, 2'd0, 2'd0, "R9 fourth");
        drive_edge(4'b0000, 8'h00, 1'b1);
        expect_out(1'b0, 2'd0, 2'd0, "R9 dropped fifth");

        // R5: held while transmitter not ready
        drive_edge(4'b1000, 8'h80, 1'b0);
        for (int k = 0; k < 3; k++) begin
            expect_out(1'b1, 2'd3, 2'd2, "R5 hold");
            drive_edge(4'b0000, 8'h00, 1'b0);
        end

        // R1: reset discards queued entries
        rst_n = 1'b0;
        drive_edge(4'b0000, 8'h00, 1'b0);
        expect_out(1'b0, 2'd0, 2'd0, "R1 reset flush");
        rst_n = 1'b1;
        drive_edge(4'b0000, 8'h00, 1'b0);
        expect_out(1'b0, 2'd0, 2'd0, "R1 stays empty");

        // R4: pointer restarts at input 0 after reset
        drive_edge(4'b1001, 8'h41, 1'b0);
        expect_out(1'b1, 2'd0, 2'd1, "R4 start at input 0");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule